// File: doc/BRIEF.md
# Sleep Mode and Clock Gating Controller

This block decides which clock domains of a small controller run while the processor is active and while it sleeps. A sleep request pulse, standing in for the sleep instruction, is honoured only when the sleep enable bit is set. The three-bit mode field selects one of five sleep depths. Each depth gates its own set of domains: processor clock, peripheral clock, oscillator keep-alive and real-time-counter clock. Each depth also accepts its own set of wake sources.

When a wake source valid for the chosen depth arrives, the peripheral clock comes back first and the processor clock one cycle later. At that point a one-cycle service strobe tells the interrupt logic to take the pending interrupt. Asynchronous reset always returns the block to the active state. A power-reduction mask stops individual peripheral clocks and blocks register access to a stopped peripheral, so its state stays frozen until the bit is cleared. The input buffers of the wake pins stay powered during sleep only where the wake pin mask needs them.

Top module: `slp_clk_ctrl`

## Requirements
- R1: While and after reset, with no request, the state is active: `cpu_clk_en`, `per_clk_en` and `osc_keep` are 1, `irq_svc` and `asleep` are 0.
- R2: A sleep request with `sleep_en` at 0 is ignored: all clock enables stay as in active mode and `asleep` stays 0.
- R3: Mode 000 (idle), and the unused codes 001, 100 and 101, stop only the processor clock. `per_clk_en` and `osc_keep` stay 1. `irq_any`, `irq_twi`, a masked pin interrupt, or `irq_rtc` with `rtc_enabled` wakes the block.
- R4: Mode 010 stops processor, peripheral, oscillator and counter clocks. Only `irq_twi` or a pin interrupt whose bit is set in `wk_pin_mask` wakes the block; `irq_any` and `irq_rtc` are ignored.
- R5: Mode 011 behaves as mode 010, except that `rtc_clk_en` equals `rtc_enabled` and `irq_rtc` also wakes the block while `rtc_enabled` is 1.
- R6: Mode 110 behaves as mode 010, except that `osc_keep` stays 1.
- R7: Mode 111 behaves as mode 011, except that `osc_keep` stays 1.
- R8: In the cycle after a wake source is sampled, `per_clk_en` is 1 and `cpu_clk_en` is 0. One cycle later `cpu_clk_en` is 1 and `irq_svc` is 1 for exactly one cycle.
- R9: While bit i of `pr_mask` is 1, `periph_clk_en[i]` and `periph_acc_ok[i]` are 0. While it is 0, `periph_clk_en[i]` equals `per_clk_en`, and `periph_acc_ok[i]` equals `periph_req[i]` gated by that enable.
- R10: `inbuf_en[j]` is 1 while `per_clk_en` is 1. Otherwise it equals `wk_pin_mask[j]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Sleep depth code |
| sleep_en | input | 1 | Sleep enable bit |
| sleep_req | input | 1 | One-cycle sleep request |
| irq_any | input | 1 | Any enabled interrupt pending |
| irq_twi | input | 1 | Two-wire bus interrupt |
| irq_pin | input | N_WAKE_PINS | Asynchronous pin interrupts |
| wk_pin_mask | input | N_WAKE_PINS | Pins allowed to wake the block |
| irq_rtc | input | 1 | Real-time counter interrupt |
| rtc_enabled | input | 1 | Real-time counter switched on |
| pr_mask | input | N_PERIPH | Power-reduction bits, one per peripheral |
| periph_req | input | N_PERIPH | Register access requests per peripheral |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_keep | output | 1 | Keep system oscillators running |
| rtc_clk_en | output | 1 | Real-time counter domain enable |
| inbuf_en | output | N_WAKE_PINS | Wake pin input buffer enables |
| periph_clk_en | output | N_PERIPH | Per-peripheral clock enables |
| periph_acc_ok | output | N_PERIPH | Register access granted per peripheral |
| irq_svc | output | 1 | One-cycle strobe to service the waking interrupt |
| asleep | output | 1 | Sleep state indicator |

## Verification
On every cycle, the assertions check the ordering rules. The processor clock never runs without the peripheral clock, and it only rises after the peripheral clock was already on. The service strobe only follows the wake step. The counter clock only runs when the counter was enabled. A request without the enable never stops the processor. A stopped peripheral never gets register access. Only the directed scenarios show which domains each mode code gates, and which wake sources each depth accepts or ignores. They also show the reserved codes falling back to idle and the pin buffer masking.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_WAKE   = 2'd2
    } slp_state_e;

    // Gating and wake policy of one sleep depth
    typedef struct packed {
        logic per;     // peripheral clock kept
        logic osc;     // oscillators kept
        logic rtc_run; // counter may run if switched on
        logic wk_any;  // any enabled interrupt wakes
        logic wk_twi;  // two-wire interrupt wakes
        logic wk_pin;  // masked pin interrupt wakes
        logic wk_rtc;  // counter interrupt wakes
    } slp_policy_t;

    localparam logic [2:0] MODE_IDLE  = 3'b000;
    localparam logic [2:0] MODE_PDOWN = 3'b010;
    localparam logic [2:0] MODE_PSAVE = 3'b011;
    localparam logic [2:0] MODE_STBY  = 3'b110;
    localparam logic [2:0] MODE_XSTBY = 3'b111;

endpackage

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
    import slp_pkg::*;
(
    input  logic [2:0]  mode_sel,
    output slp_policy_t policy
);
    always_comb begin
        // deep-sleep baseline, then relax per mode
        policy = '{per: 1'b0, osc: 1'b0, rtc_run: 1'b0, wk_any: 1'b0,
                   wk_twi: 1'b1, wk_pin: 1'b1, wk_rtc: 1'b0};
        unique case (mode_sel)
            MODE_PDOWN: ;
            MODE_PSAVE: begin
                policy.rtc_run = 1'b1;
                policy.wk_rtc  = 1'b1;
            end
            MODE_STBY: policy.osc = 1'b1;
            MODE_XSTBY: begin
                policy.osc     = 1'b1;
                policy.rtc_run = 1'b1;
                policy.wk_rtc  = 1'b1;
            end
            default: begin // idle and unused codes
                policy.per     = 1'b1;
                policy.osc     = 1'b1;
                policy.rtc_run = 1'b1;
                policy.wk_any  = 1'b1;
                policy.wk_rtc  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/slp_seq.sv
module slp_seq
    import slp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep_en,
    input  logic        sleep_req,
    input  slp_policy_t policy_in,
    input  logic        irq_any,
    input  logic        irq_twi,
    input  logic        pin_wake,
    input  logic        irq_rtc,
    input  logic        rtc_enabled,
    output logic        cpu_clk_en,
    output logic        per_clk_en,
    output logic        osc_keep,
    output logic        rtc_clk_en,
    output logic        irq_svc,
    output logic        asleep
);
    typedef struct packed {
        slp_state_e  state;
        slp_policy_t pol;
        logic        cpu;
        logic        per;
        logic        osc;
        logic        rtc;
        logic        svc;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      wake_hit;

    always_comb begin
        wake_hit = (r_q.pol.wk_any & irq_any)
                 | (r_q.pol.wk_twi & irq_twi)
                 | (r_q.pol.wk_pin & pin_wake)
                 | (r_q.pol.wk_rtc & irq_rtc & rtc_enabled);
        r_d     = r_q;
        r_d.svc = 1'b0;
        unique case (r_q.state)
            ST_ACTIVE: begin
                r_d.cpu = 1'b1;
                r_d.per = 1'b1;
                r_d.osc = 1'b1;
                r_d.rtc = rtc_enabled;
                if (sleep_req && sleep_en) begin
                    r_d.state = ST_SLEEP;
                    r_d.pol   = policy_in;
                    r_d.cpu   = 1'b0;
                    r_d.per   = policy_in.per;
                    r_d.osc   = policy_in.osc;
                    r_d.rtc   = policy_in.rtc_run & rtc_enabled;
                end
            end
            ST_SLEEP: begin
                r_d.rtc = r_q.pol.rtc_run & rtc_enabled;
                if (wake_hit) begin
                    r_d.state = ST_WAKE;
                    r_d.per   = 1'b1;
                    r_d.osc   = 1'b1;
                    r_d.rtc   = rtc_enabled;
                end
            end
            default: begin // ST_WAKE: processor clock one cycle after peripherals
                r_d.state = ST_ACTIVE;
                r_d.cpu   = 1'b1;
                r_d.svc   = 1'b1;
                r_d.rtc   = rtc_enabled;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_ACTIVE, pol: '0, cpu: 1'b1, per: 1'b1,
                     osc: 1'b1, rtc: 1'b0, svc: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_clk_en = r_q.cpu;
    assign per_clk_en = r_q.per;
    assign osc_keep   = r_q.osc;
    assign rtc_clk_en = r_q.rtc;
    assign irq_svc    = r_q.svc;
    assign asleep     = (r_q.state == ST_SLEEP);

    assert_cpu_needs_per_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> per_clk_en);
    assert_cpu_after_per_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> $past(per_clk_en));
    assert_svc_after_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_svc |-> $past(r_q.state == ST_WAKE));
    assert_no_sleep_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ACTIVE && sleep_req && !sleep_en) |=> cpu_clk_en);
    assert_rtc_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rtc_clk_en) |-> $past(rtc_enabled));
endmodule

// File: rtl/slp_pr_gate.sv
module slp_pr_gate #(
    parameter int N_PERIPH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                per_clk_en,
    input  logic [N_PERIPH-1:0] pr_mask,
    input  logic [N_PERIPH-1:0] periph_req,
    output logic [N_PERIPH-1:0] periph_clk_en,
    output logic [N_PERIPH-1:0] periph_acc_ok
);
    for (genvar i = 0; i < N_PERIPH; i++) begin : g_per
        assign periph_clk_en[i] = per_clk_en & ~pr_mask[i];
        assign periph_acc_ok[i] = periph_req[i] & periph_clk_en[i];

        assert_no_access_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
            pr_mask[i] |-> !periph_acc_ok[i]);
    end
endmodule

// File: rtl/slp_clk_ctrl.sv
module slp_clk_ctrl
    import slp_pkg::*;
#(
    parameter int N_PERIPH    = 8,
    parameter int N_WAKE_PINS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             mode_sel,
    input  logic                   sleep_en,
    input  logic                   sleep_req,
    input  logic                   irq_any,
    input  logic                   irq_twi,
    input  logic [N_WAKE_PINS-1:0] irq_pin,
    input  logic [N_WAKE_PINS-1:0] wk_pin_mask,
    input  logic                   irq_rtc,
    input  logic                   rtc_enabled,
    input  logic [N_PERIPH-1:0]    pr_mask,
    input  logic [N_PERIPH-1:0]    periph_req,
    output logic                   cpu_clk_en,
    output logic                   per_clk_en,
    output logic                   osc_keep,
    output logic                   rtc_clk_en,
    output logic [N_WAKE_PINS-1:0] inbuf_en,
    output logic [N_PERIPH-1:0]    periph_clk_en,
    output logic [N_PERIPH-1:0]    periph_acc_ok,
    output logic                   irq_svc,
    output logic                   asleep
);
    slp_policy_t policy;
    logic        pin_wake;

    assign pin_wake = |(irq_pin & wk_pin_mask);

    slp_mode_decode i_decode (
        .mode_sel (mode_sel),
        .policy   (policy)
    );

    slp_seq i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_en    (sleep_en),
        .sleep_req   (sleep_req),
        .policy_in   (policy),
        .irq_any     (irq_any),
        .irq_twi     (irq_twi),
        .pin_wake    (pin_wake),
        .irq_rtc     (irq_rtc),
        .rtc_enabled (rtc_enabled),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .osc_keep    (osc_keep),
        .rtc_clk_en  (rtc_clk_en),
        .irq_svc     (irq_svc),
        .asleep      (asleep)
    );

    slp_pr_gate #(.N_PERIPH(N_PERIPH)) i_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .per_clk_en    (per_clk_en),
        .pr_mask       (pr_mask),
        .periph_req    (periph_req),
        .periph_clk_en (periph_clk_en),
        .periph_acc_ok (periph_acc_ok)
    );

    for (genvar j = 0; j < N_WAKE_PINS; j++) begin : g_buf
        assign inbuf_en[j] = per_clk_en | wk_pin_mask[j];

        assert_buf_off_unmasked_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!per_clk_en && !wk_pin_mask[j]) |-> !inbuf_en[j]);
    end

    assert_no_cpu_asleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !cpu_clk_en);
endmodule

// File: tb/test_slp_clk_ctrl.sv
module test_slp_clk_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode_sel = 3'b000;
    logic          sleep_en = 1'b0, sleep_req = 1'b0;
    logic          irq_any = 1'b0, irq_twi = 1'b0, irq_rtc = 1'b0, rtc_enabled = 1'b1;
    logic [NW-1:0] irq_pin = '0, wk_pin_mask = '0;
    logic [NP-1:0] pr_mask = '0, periph_req = '0;
    logic          cpu_clk_en, per_clk_en, osc_keep, rtc_clk_en, irq_svc, asleep;
    logic [NW-1:0] inbuf_en;
    logic [NP-1:0] periph_clk_en, periph_acc_ok;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slp_clk_ctrl #(.N_PERIPH(NP), .N_WAKE_PINS(NW)) i_slp_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_en(sleep_en),
        .sleep_req(sleep_req), .irq_any(irq_any), .irq_twi(irq_twi),
        .irq_pin(irq_pin), .wk_pin_mask(wk_pin_mask), .irq_rtc(irq_rtc),
        .rtc_enabled(rtc_enabled), .pr_mask(pr_mask), .periph_req(periph_req),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_keep(osc_keep),
        .rtc_clk_en(rtc_clk_en), .inbuf_en(inbuf_en), .periph_clk_en(periph_clk_en),
        .periph_acc_ok(periph_acc_ok), .irq_svc(irq_svc), .asleep(asleep)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // {cpu, per, osc, rtc, asleep}
    function automatic logic [4:0] clocks();
        return {cpu_clk_en, per_clk_en, osc_keep, rtc_clk_en, asleep};
    endfunction

    task automatic enter_sleep(logic [2:0] m, logic en);
        @(negedge clk);
        mode_sel  = m;
        sleep_en  = en;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    // wake inputs already driven; checks the two-step return
    task automatic wake_and_check(string req);
        @(negedge clk);
        irq_any = 0; irq_twi = 0; irq_rtc = 0; irq_pin = '0;
        chk({req, " R8 per first"}, {30'd0, per_clk_en, cpu_clk_en}, 32'b10);
        @(negedge clk);
        chk({req, " R8 cpu back"}, {30'd0, cpu_clk_en, irq_svc}, 32'b11);
        @(negedge clk);
        chk({req, " R8 svc one cycle"}, {31'd0, irq_svc}, 32'd0);
    endtask

    task automatic hold_ignored(string req);
        @(negedge clk);
        @(negedge clk);
        irq_any = 0; irq_twi = 0; irq_rtc = 0; irq_pin = '0;
        chk({req, " ignored wake"}, {31'd0, asleep}, 32'd1);
    endtask

    task automatic t_reset();
        #(CLK_PERIOD*2);
        chk("R1 reset clocks", {27'd0, cpu_clk_en, per_clk_en, osc_keep, irq_svc, asleep}, 32'b11100);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {27'd0, clocks()}, 32'b11110);
    endtask

    task automatic t_no_enable();
        enter_sleep(3'b010, 1'b0);
        chk("R2 request without enable", {27'd0, clocks()}, 32'b11110);
        @(negedge clk);
        chk("R2 still active", {27'd0, clocks()}, 32'b11110);
    endtask

    task automatic t_idle(logic [2:0] m, string req);
        enter_sleep(m, 1'b1);
        chk({req, " idle gating"}, {27'd0, clocks()}, 32'b01111);
        irq_any = 1'b1;
        wake_and_check(req);
    endtask

    task automatic t_pdown();
        wk_pin_mask = 4'b0101;
        enter_sleep(3'b010, 1'b1);
        chk("R4 power-down gating", {27'd0, clocks()}, 32'b00001);
        chk("R10 masked buffers", {28'd0, inbuf_en}, 32'b0101);
        chk("R9 all peripherals stopped", {24'd0, periph_clk_en}, 32'd0);
        irq_any = 1'b1; irq_rtc = 1'b1;
        hold_ignored("R4 any/rtc");
        irq_pin = 4'b0010;  // unmasked pin
        hold_ignored("R4 unmasked pin");
        irq_pin = 4'b0100;
        wake_and_check("R4 pin");
        chk("R10 buffers back", {28'd0, inbuf_en}, 32'b1111);
        enter_sleep(3'b010, 1'b1);
        irq_twi = 1'b1;
        wake_and_check("R4 twi");
        wk_pin_mask = '0;
    endtask

    task automatic t_psave();
        enter_sleep(3'b011, 1'b1);
        chk("R5 power-save gating", {27'd0, clocks()}, 32'b00011);
        irq_any = 1'b1;
        hold_ignored("R5 any");
        irq_rtc = 1'b1;
        wake_and_check("R5 rtc");
    endtask

    task automatic t_standby();
        enter_sleep(3'b110, 1'b1);
        chk("R6 standby gating", {27'd0, clocks()}, 32'b00101);
        irq_rtc = 1'b1;
        hold_ignored("R6 rtc");
        irq_twi = 1'b1;
        wake_and_check("R6 twi");
    endtask

    task automatic t_xstandby();
        enter_sleep(3'b111, 1'b1);
        chk("R7 ext standby gating", {27'd0, clocks()}, 32'b00111);
        irq_any = 1'b1;
        hold_ignored("R7 any");
        irq_rtc = 1'b1;
        wake_and_check("R7 rtc");
    endtask

    task automatic t_pr();
        @(negedge clk);
        pr_mask = 8'h05; periph_req = 8'hFF;
        #1;
        chk("R9 clocks with mask", {24'd0, periph_clk_en}, 32'hFA);
        chk("R9 access with mask", {24'd0, periph_acc_ok}, 32'hFA);
        @(negedge clk);
        pr_mask = 8'h00; periph_req = 8'h30;
        #1;
        chk("R9 clocks cleared", {24'd0, periph_clk_en}, 32'hFF);
        chk("R9 access cleared", {24'd0, periph_acc_ok}, 32'h30);
        periph_req = '0;
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_no_enable();
                t_idle(3'b000, "R3 mode 000");
                t_idle(3'b001, "R3 mode 001");
                t_idle(3'b100, "R3 mode 100");
                t_idle(3'b101, "R3 mode 101");
                t_pdown();
                t_psave();
                t_standby();
                t_xstandby();
                t_pr();
            end
            begin
                #(CLK_PERIOD*5000);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule